// File: doc/BRIEF.md
# Output short-circuit fault retry controller

This block supervises a single output driver. An analog current-limit comparator outside the block reports an overload as one digital overcurrent flag. While the driver is on, the block counts how many cycles the flag has stayed high without a break. It declares a fault only when that run covers a full detection window. At that point it switches the driver off, raises a live fault status bit and a sticky fault-interrupt bit, and pulls an active-low interrupt line.

After a fault the block does not simply latch off. It waits out an off period and then turns the driver back on for one probe window of the same length as the detection window. The time from one probe start to the next is one retry period. A probe that again sees a full window of overcurrent re-declares the fault and starts another off period. A probe that completes without one returns the driver to normal operation and clears the live bit. The sticky bit and the interrupt stay set until a status-read strobe clears them. The enable request can take the driver off at any time, and doing so cancels any retry in progress.

All intervals are given in microseconds and turned into clock cycles from a clock-rate parameter. By default these are 440 us for detection and for each probe, and 26 ms for the retry period.

Top module: `short_retry_ctrl`

## Requirements
- R1: While reset is held (synchronous, active low), drv_en, fault_live and fault_sticky are 0 and irq_n is 1.
- R2: While the driver is on, a fault is declared at the clock edge that samples oc_flag high for the DET-th consecutive cycle, where DET = CLK_KHZ*DETECT_US/1000. In the cycle after that edge, drv_en is 0 and fault_live is 1. With fewer consecutive high samples, drv_en stays 1 and fault_live stays 0.
- R3: A single low sample of oc_flag restarts the consecutive count. Any run shorter than DET high samples declares no fault.
- R4: After a fault, drv_en stays 0 for OFF = PER - DET cycles and then returns to 1 for a probe window of DET cycles. PER = CLK_KHZ*RETRY_US/1000, so probe starts are PER cycles apart.
- R5: If oc_flag stays high for the whole probe window, the fault is declared again at the window's last edge. The driver goes back off, fault_live stays 1 and fault_sticky is set again.
- R6: If a probe window ends without a full detection run, the driver stays on in normal operation and fault_live clears. fault_sticky keeps its value.
- R7: Each fault declaration sets fault_sticky. irq_n is 0 exactly while fault_sticky is 1, both updated at the same edge.
- R8: A stat_rd pulse clears fault_sticky and raises irq_n at the next edge, unless a fault is declared at that same edge. In that case the sticky bit stays 1.
- R9: With en_req low, drv_en and fault_live are 0 from the next cycle, any retry is abandoned, and oc_flag has no effect. fault_sticky is kept. Raising en_req turns the driver on at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_req | input | 1 | Request to turn the output driver on |
| oc_flag | input | 1 | Overcurrent flag from the current-limit comparator |
| stat_rd | input | 1 | One-cycle strobe marking a read of the status bits |
| drv_en | output | 1 | Output driver enable |
| fault_live | output | 1 | Fault currently active (off period or probe) |
| fault_sticky | output | 1 | Sticky fault-interrupt bit |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
Every result is registered, so each output change is due one cycle after the edge that samples its cause. A fault appears after the DET-th high sample of oc_flag. A probe begins OFF edges after the fault, a probe verdict lands DET edges after the probe begins, and a read or enable change takes effect one edge later. The bench drives inputs on the falling edge. It advances an exact number of rising edges and then samples on the following falling edge. It checks each boundary from both sides: one edge before, where the old value must hold, and at the due edge, where the new value must appear. The time constants are scaled down to 8 and 40 cycles so that whole retry cycles fit in a short run.

// File: rtl/srf_pkg.sv
// Shared types for the short-circuit retry controller.
// Assumes: nothing beyond IEEE 1800-2017.
package srf_pkg;

    // Driver supervision phases
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // driver off by request
        ST_RUN   = 2'd1,   // driver on, normal operation
        ST_OFF   = 2'd2,   // driver off after a fault, waiting
        ST_PROBE = 2'd3    // driver on briefly to test the short
    } drv_state_e;

endpackage

// File: rtl/srf_oc_window.sv
// Consecutive-overcurrent window detector.
// Counts the clock cycles for which the qualified overcurrent sample has
// been high without a break. hit pulses on the WIN-th consecutive sample.
// Assumes: WIN >= 2; sample is already qualified with the driver being on.
module srf_oc_window #(
    parameter int unsigned WIN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample,
    output logic hit
);
    localparam int unsigned CW = $clog2(WIN + 1);

    logic [CW-1:0] run_cnt;

    // Window complete on this sample
    assign hit = sample && (run_cnt == CW'(WIN - 1));

    // Run-length counter: restarts on a gap or after a completed window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (!sample || hit) begin
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + CW'(1);
        end
    end

    // R3: the run count never reaches the window length
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt < CW'(WIN));

    // R3: a gap in overcurrent restarts the count
    p_gap_resets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sample |=> run_cnt == '0);

endmodule

// File: rtl/srf_phase_timer.sv
// Phase timer for the off period and the probe window.
// Counts cycles while run is high and restarts on clr. done marks the
// last cycle of a phase of lim cycles.
// Assumes: lim >= 1 and is stable for the length of a phase.
module srf_phase_timer #(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          clr,
    input  logic [TW-1:0] lim,
    output logic          done
);
    logic [TW-1:0] ph_cnt;

    // Last cycle of the current phase
    assign done = run && (ph_cnt == lim - TW'(1));

    // Phase counter: held at zero outside timed phases
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_cnt <= '0;
        end else if (!run || clr) begin
            ph_cnt <= '0;
        end else begin
            ph_cnt <= ph_cnt + TW'(1);
        end
    end

    // R4: a timed phase never outlives its length
    p_phase_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> ph_cnt < lim);

endmodule

// File: rtl/srf_status.sv
// Sticky fault-interrupt bit and active-low interrupt request.
// A fault event sets the bit; a read strobe clears it. The event wins
// when both arrive in one cycle.
// Assumes: evt is a single-cycle pulse per fault declaration.
module srf_status (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic rd,
    output logic sticky,
    output logic irq_n
);
    logic sticky_nx;

    // Next value of the sticky bit, set has priority over clear
    assign sticky_nx = evt || (sticky && !rd);

    // Sticky bit and interrupt line registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky <= 1'b0;
            irq_n  <= 1'b1;
        end else begin
            sticky <= sticky_nx;
            irq_n  <= !sticky_nx;
        end
    end

    // R7: a fault event sets the sticky bit and asserts the interrupt
    p_evt_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> sticky && !irq_n);

    // R8: a read with no coincident event clears the bit and the interrupt
    p_rd_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd && !evt |=> !sticky && irq_n);

    // R8: with neither event nor read the bit holds
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd && !evt |=> $stable(sticky));

endmodule

// File: rtl/short_retry_ctrl.sv
// Output short-circuit fault retry controller (top).
// Supervises one driver: declares a fault after DET consecutive cycles of
// overcurrent, turns the driver off, and probes it again every PER cycles
// for DET cycles until a probe passes. Reports through live/sticky bits
// and an active-low interrupt.
// Assumes: oc_flag is synchronous to clk; RETRY_US > DETECT_US; at least
// two cycles per detection window.
module short_retry_ctrl #(
    parameter int unsigned CLK_KHZ   = 50000,
    parameter int unsigned DETECT_US = 440,
    parameter int unsigned RETRY_US  = 26000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_req,
    input  logic oc_flag,
    input  logic stat_rd,
    output logic drv_en,
    output logic fault_live,
    output logic fault_sticky,
    output logic irq_n
);
    import srf_pkg::*;

    localparam int unsigned DET_CYC = (CLK_KHZ * DETECT_US) / 1000;
    localparam int unsigned PER_CYC = (CLK_KHZ * RETRY_US) / 1000;
    localparam int unsigned OFF_CYC = PER_CYC - DET_CYC;
    localparam int unsigned MAX_PH  = (OFF_CYC > DET_CYC) ? OFF_CYC : DET_CYC;
    localparam int unsigned TW      = $clog2(MAX_PH + 1);

    drv_state_e    state, state_nx;
    logic          oc_sample;
    logic          oc_hit;
    logic          ph_run;
    logic          ph_clr;
    logic          ph_done;
    logic [TW-1:0] ph_lim;

    // Driver is on in normal operation and during a probe
    assign drv_en    = (state == ST_RUN) || (state == ST_PROBE);
    // Overcurrent only counts while the driver is on and requested
    assign oc_sample = oc_flag && drv_en && en_req;
    // Timer runs in the two timed phases, restarted on every phase change
    assign ph_run    = (state == ST_OFF) || (state == ST_PROBE);
    assign ph_clr    = (state != state_nx);
    assign ph_lim    = (state == ST_OFF) ? TW'(OFF_CYC) : TW'(DET_CYC);

    srf_oc_window #(
        .WIN    (DET_CYC)
    ) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (oc_sample),
        .hit    (oc_hit)
    );

    srf_phase_timer #(
        .TW     (TW)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (ph_run),
        .clr    (ph_clr),
        .lim    (ph_lim),
        .done   (ph_done)
    );

    srf_status u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (oc_hit),
        .rd     (stat_rd),
        .sticky (fault_sticky),
        .irq_n  (irq_n)
    );

    // Phase sequencing: request, fault, off period, probe verdict
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:  if (en_req) state_nx = ST_RUN;
            ST_RUN:   if (!en_req) state_nx = ST_IDLE;
                      else if (oc_hit) state_nx = ST_OFF;
            ST_OFF:   if (!en_req) state_nx = ST_IDLE;
                      else if (ph_done) state_nx = ST_PROBE;
            ST_PROBE: if (!en_req) state_nx = ST_IDLE;
                      else if (oc_hit) state_nx = ST_OFF;
                      else if (ph_done) state_nx = ST_RUN;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Live fault bit: set on declaration, cleared by a passing probe or disable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_live <= 1'b0;
        end else if (!en_req) begin
            fault_live <= 1'b0;
        end else if (oc_hit) begin
            fault_live <= 1'b1;
        end else if ((state == ST_PROBE) && ph_done) begin
            fault_live <= 1'b0;
        end
    end

    // R2: a declared fault turns the driver off and marks the fault live
    p_drv_off_after_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
        oc_hit |=> !drv_en && fault_live);

    // R5: during the off period the fault stays live
    p_off_is_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |-> fault_live && !drv_en);

    // R6: a probe ending without a fault resumes normal operation
    p_probe_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROBE) && ph_done && !oc_hit && en_req |=> drv_en && !fault_live);

    // R9: dropping the request turns the driver off and clears the live bit
    p_disable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_req |=> !drv_en && !fault_live);

endmodule

// File: tb/sim_short_retry_ctrl.sv
`timescale 1ns/100ps
// Bench for short_retry_ctrl with scaled timing: DET = 8, PER = 40, OFF = 32.
module sim_short_retry_ctrl;

    localparam int DET = 8;
    localparam int PER = 40;
    localparam int OFF = PER - DET;
    localparam int NVEC = 5;
    // {overcurrent run length, fault expected}
    localparam int VEC [NVEC][2] = '{'{1, 0}, '{5, 0}, '{7, 0}, '{8, 1}, '{12, 1}};

    logic clk = 1'b0;
    logic rst_n, en_req, oc_flag, stat_rd;
    logic drv_en, fault_live, fault_sticky, irq_n;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;

    always #2.5 clk = ~clk;

    short_retry_ctrl #(
        .CLK_KHZ   (1000),
        .DETECT_US (DET),
        .RETRY_US  (PER)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_req       (en_req),
        .oc_flag      (oc_flag),
        .stat_rd      (stat_rd),
        .drv_en       (drv_en),
        .fault_live   (fault_live),
        .fault_sticky (fault_sticky),
        .irq_n        (irq_n)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic read_status();
        stat_rd = 1'b1;
        tick(1);
        stat_rd = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; en_req = 1'b1; oc_flag = 1'b1; stat_rd = 1'b0;
        tick(3);
        chk(drv_en, 0, "R1 drv_en in reset");
        chk(fault_live, 0, "R1 fault_live in reset");
        chk(fault_sticky, 0, "R1 fault_sticky in reset");
        chk(irq_n, 1, "R1 irq_n in reset");
        oc_flag = 1'b0; rst_n = 1'b1;
        tick(1);
        chk(drv_en, 1, "R9 driver on after request");

        // Table walk: overcurrent runs of several lengths
        for (int i = 0; i < NVEC; i++) begin
            oc_flag = 1'b1;
            tick(VEC[i][0]);
            chk(fault_live, VEC[i][1], "R2/R3 fault_live after run");
            chk(drv_en, 1 - VEC[i][1], "R2/R3 drv_en after run");
            chk(fault_sticky, VEC[i][1], "R7 sticky after run");
            oc_flag = 1'b0;
            tick(PER + 5);
            chk(fault_live, 0, "R6 recovered after table run");
            chk(drv_en, 1, "R6 driver on after table run");
            read_status();
            chk(irq_n, 1, "R8 irq released after read");
        end

        // R2 exact detection edge
        oc_flag = 1'b1;
        tick(DET - 1);
        chk(drv_en, 1, "R2 one edge before window end");
        chk(fault_live, 0, "R2 no fault one edge early");
        tick(1);
        chk(drv_en, 0, "R2 driver off at window end");
        chk(fault_live, 1, "R2 fault live at window end");
        chk(irq_n, 0, "R7 irq asserted on fault");
        // R8 read during off period
        read_status();
        chk(fault_sticky, 0, "R8 sticky cleared by read");
        chk(irq_n, 1, "R8 irq released by read");
        chk(fault_live, 1, "R8 read leaves live bit");
        // R4 off period length
        tick(OFF - 2);
        chk(drv_en, 0, "R4 driver off one edge before probe");
        tick(1);
        chk(drv_en, 1, "R4 probe begins after off period");
        // R5 persistent short fails the probe
        tick(DET);
        chk(drv_en, 0, "R5 driver off after failed probe");
        chk(fault_live, 1, "R5 live stays after failed probe");
        chk(fault_sticky, 1, "R5 sticky set again");
        chk(irq_n, 0, "R7 irq asserted again");
        // R6 next probe passes
        oc_flag = 1'b0;
        tick(OFF);
        chk(drv_en, 1, "R4 second probe one period later");
        tick(DET - 1);
        chk(fault_live, 1, "R6 live until probe ends");
        tick(1);
        chk(fault_live, 0, "R6 live cleared after passing probe");
        chk(drv_en, 1, "R6 driver stays on");
        chk(fault_sticky, 1, "R6 sticky kept");

        // R8 read coinciding with a new fault
        oc_flag = 1'b1;
        tick(DET - 1);
        stat_rd = 1'b1;
        tick(1);
        stat_rd = 1'b0;
        chk(fault_sticky, 1, "R8 fault wins over read");
        chk(irq_n, 0, "R8 irq held by coincident fault");
        oc_flag = 1'b0;
        tick(PER + 5);
        read_status();
        chk(fault_sticky, 0, "R8 cleared after recovery");

        // R3 interrupted overcurrent
        oc_flag = 1'b1; tick(DET - 1);
        oc_flag = 1'b0; tick(1);
        oc_flag = 1'b1; tick(DET - 1);
        chk(fault_live, 0, "R3 gap restarts window");
        chk(drv_en, 1, "R3 driver on after split runs");
        oc_flag = 1'b0; tick(1);

        // R9 disable cancels retry, overcurrent ignored
        oc_flag = 1'b1;
        tick(DET);
        chk(fault_live, 1, "R9 fault before disable");
        en_req = 1'b0;
        tick(1);
        chk(drv_en, 0, "R9 driver off when not requested");
        chk(fault_live, 0, "R9 live cleared by disable");
        chk(fault_sticky, 1, "R9 sticky kept by disable");
        read_status();
        tick(PER + 20);
        chk(drv_en, 0, "R9 no probe while disabled");
        chk(fault_sticky, 0, "R9 overcurrent ignored while disabled");
        chk(irq_n, 1, "R9 irq idle while disabled");
        oc_flag = 1'b0; en_req = 1'b1;
        tick(1);
        chk(drv_en, 1, "R9 driver on after re-request");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule